// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block watches that software keeps running in its intended order. A free-running counter advances on every clock cycle in which the clock-gate input is low. A 3-bit rate code picks one of seven timeout lengths, or turns the watchdog off. To restart the count, software writes a two-byte key to the arm register: first 0x55, then 0xAA. If the count reaches the end of the selected period first, the block raises a one-cycle reset request for the system reset logic.

Any byte written to the arm register other than the two key values raises the request at once. An optional window mode can also be turned on. In that mode, an arm write counts as valid only in the final quarter of the period, and an arm write made earlier raises the request at once. The `clkGate` input stands for wait or stop modes: while it is high, the counter holds its value.

Top module: `wdt_keyed`

## Requirements
- R1: When the rate code is 000, the counter does not run, no reset request is raised, and writes to the arm register are ignored.
- R2: Let B be the parameter `BASE_LOG2` (default 14). Rate codes 001 to 111 select periods of 2^B, 2^(B+2), 2^(B+4), 2^(B+6), 2^(B+8), 2^(B+9) and 2^(B+10) ungated cycles. After a restart, `resetReq` rises on the cycle that follows the P-th counting cycle, where P is the selected period.
- R3: Writing 0x55 and then 0xAA to the arm register (`wrSel`=1) clears the counter and the key state. A repeated 0x55 keeps the block waiting for 0xAA. A 0xAA with no 0x55 before it does not restart the count.
- R4: Writing any byte other than 0x55 or 0xAA to the arm register, while the watchdog is on, makes `resetReq` high on the next cycle.
- R5: When window mode is on (control bit 3), an arm write made while the count is below three quarters of the period makes `resetReq` high on the next cycle. At or above that point, the write is handled as in R3 and R4.
- R6: While `clkGate` is high, the counter holds its value and cannot time out.
- R7: `resetReq` is high for exactly one cycle. On that cycle, the counter and the key state go back to zero.
- R8: A write with `wrSel`=0 loads the rate code from bits 2:0 and the window enable from bit 3. The same write clears the counter and the key state, so the new period starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkGate | input | 1 | High during low-power modes; stops the counter |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control register, 1 selects the arm register |
| wrData | input | 8 | Write data |
| resetReq | output | 1 | One-cycle reset request |

## Verification
The bench measures the exact cycle of each timeout. A design off by one count would fire one cycle early or late, and a design with a wrong divider chain would miss the 2^(B+2) and 2^(B+10) lengths. Several tests look at the key order. A design that accepted a lone 0xAA would push back the timeout, and one that dropped the armed state on a second 0x55 would fail to restart. The window edge is probed on both sides, at count 11 and at count 12 of a 16-cycle period; an off-by-one compare there either rejects a valid write or lets through an early one. Further tests confirm that a gated clock freezes the count, that a bad key byte clears the counter, and that a control write clears the counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
  } wdtStrobe_t;

  // extra doublings over the base stage for each rate code
  function automatic int rateShift(input logic [2:0] rate);
    case (rate)
      3'd1:    return 0;
      3'd2:    return 2;
      3'd3:    return 4;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 9;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [2:0]       rate,
  output logic [CNT_W-1:0] count,
  output logic             atEnd,
  output logic             inWindow
);

  localparam int PER_W = CNT_W + 1;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] lastVal;
  logic [PER_W-1:0] winStart;
  logic [PER_W-1:0] countExt;

  always_comb begin
    period   = PER_W'(1) << (BASE_LOG2 + rateShift(rate));
    lastVal  = period - PER_W'(1);
    winStart = period - (period >> 2);
    countExt = {1'b0, count};
    atEnd    = (countExt == lastVal);
    inWindow = (countExt >= winStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.cntClr) count <= '0;
    else if (strobe.cntRun) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkGate,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       atEnd,
  input  logic       inWindow,
  output wdtStrobe_t strobe,
  output logic [2:0] rate,
  output logic       winEn,
  output logic       resetReq
);

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  logic seqArmed;
  logic active, ctrlWr, armWr, isFirst, isSecond;
  logic badVal, early, keyDone, timeout, reqSet;

  always_comb begin
    active   = (rate != 3'd0);
    ctrlWr   = wrEn && !wrSel;
    armWr    = wrEn && wrSel && active;
    isFirst  = (wrData == KEY_FIRST);
    isSecond = (wrData == KEY_SECOND);
    badVal   = armWr && !isFirst && !isSecond;
    early    = armWr && winEn && !inWindow;
    keyDone  = armWr && isSecond && seqArmed && !early;
    timeout  = active && !clkGate && atEnd && !keyDone && !ctrlWr;
    reqSet   = badVal || early || timeout;
    strobe.cntClr = resetReq || ctrlWr || keyDone;
    strobe.cntRun = active && !clkGate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rate     <= 3'd0;
      winEn    <= 1'b0;
      seqArmed <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= reqSet && !resetReq;
      if (ctrlWr) begin
        rate  <= wrData[2:0];
        winEn <= wrData[3];
      end
      if (resetReq || ctrlWr)               seqArmed <= 1'b0;
      else if (armWr && !early && isFirst)  seqArmed <= 1'b1;
      else if (keyDone)                     seqArmed <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkGate,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  output logic       resetReq
);

  localparam int CNT_W = BASE_LOG2 + 10;

  wdtStrobe_t       strobe;
  logic [2:0]       rate;
  logic             winEn;
  logic [CNT_W-1:0] count;
  logic             atEnd;
  logic             inWindow;

  wdt_control u_ctrl (
    .clk(clk), .rstN(rstN), .clkGate(clkGate), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .atEnd(atEnd), .inWindow(inWindow), .strobe(strobe),
    .rate(rate), .winEn(winEn), .resetReq(resetReq)
  );

  wdt_datapath #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rate(rate),
    .count(count), .atEnd(atEnd), .inWindow(inWindow)
  );

endmodule

// File: rtl/wdt_keyed_checker.sv
module wdt_keyed_checker
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkGate,
  input logic             wrEn,
  input logic             wrSel,
  input logic [7:0]       wrData,
  input logic             resetReq,
  input logic [2:0]       rate,
  input logic             winEn,
  input logic [CNT_W-1:0] count
);

  logic [CNT_W:0] threeQuarter;
  logic           armBad;
  logic           armEarly;

  always_comb begin
    threeQuarter = (CNT_W+1)'(3) << (BASE_LOG2 + rateShift(rate) - 2);
    armBad   = wrEn && wrSel && (rate != 3'd0) && (wrData != 8'h55) && (wrData != 8'hAA);
    armEarly = wrEn && wrSel && (rate != 3'd0) && winEn && ({1'b0, count} < threeQuarter);
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r7_clear_after: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (count == '0));

  a_r4_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (armBad && !resetReq) |=> resetReq);

  a_r5_early_write: assert property (@(posedge clk) disable iff (!rstN)
    (armEarly && !resetReq) |=> resetReq);

  a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkGate && !resetReq && !wrEn) |=> (count == $past(count)));

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rate == 3'd0) |=> !resetReq);

endmodule

bind wdt_keyed wdt_keyed_checker #(.BASE_LOG2(BASE_LOG2)) chk (
  .clk(clk), .rstN(rstN), .clkGate(clkGate), .wrEn(wrEn), .wrSel(wrSel),
  .wrData(wrData), .resetReq(resetReq), .rate(rate), .winEn(winEn), .count(count)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

  localparam int CLK_PERIOD = 10;
  localparam int B  = 4;
  localparam int P1 = 1 << B;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkGate = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       resetReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed #(.BASE_LOG2(B)) uut (
    .clk(clk), .rstN(rstN), .clkGate(clkGate), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .resetReq(resetReq)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: resetReq=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // caller is at a negedge; write is taken at the next posedge
  task automatic doWrite(input logic sel, input logic [7:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counter is at value c; expects no request until the end, then one pulse
  task automatic expectTimeout(input string tag, input int period, input int c);
    idle(period - 1 - c);
    check({tag, " quiet before end"}, resetReq, 1'b0);
    idle(1);
    check({tag, " request at end"}, resetReq, 1'b1);
    idle(1);
    check({tag, " one cycle wide (R7)"}, resetReq, 1'b0);
    idle(2);
  endtask

  task automatic testDisabled();
    doWrite(1'b0, 8'h00);
    idle(200);
    check("R1 no timeout when off", resetReq, 1'b0);
    doWrite(1'b1, 8'h3C);
    check("R1 arm write ignored when off", resetReq, 1'b0);
    idle(2);
  endtask

  task automatic testPeriods();
    doWrite(1'b0, 8'h01);
    expectTimeout("R2 code1", P1, 0);
    doWrite(1'b0, 8'h02);
    expectTimeout("R2 code2", P1 * 4, 0);
    doWrite(1'b0, 8'h07);
    expectTimeout("R2 code7", P1 * 1024, 0);
  endtask

  task automatic testService();
    doWrite(1'b0, 8'h01);
    idle(5);
    doWrite(1'b1, 8'h55);
    doWrite(1'b1, 8'hAA);
    expectTimeout("R3 key restarts", P1, 0);
    doWrite(1'b0, 8'h01);
    idle(5);
    doWrite(1'b1, 8'hAA);
    expectTimeout("R3 lone AA no restart", P1, 6);
    doWrite(1'b0, 8'h01);
    idle(3);
    doWrite(1'b1, 8'h55);
    doWrite(1'b1, 8'h55);
    doWrite(1'b1, 8'hAA);
    expectTimeout("R3 double 55 restarts", P1, 0);
  endtask

  task automatic testBadKey();
    doWrite(1'b0, 8'h01);
    idle(7);
    doWrite(1'b1, 8'h3C);
    check("R4 bad key request", resetReq, 1'b1);
    idle(1);
    check("R7 bad key pulse ends", resetReq, 1'b0);
    expectTimeout("R7 counter cleared by request", P1, 0);
  endtask

  task automatic testWindow();
    doWrite(1'b0, 8'h09);
    idle(11);
    doWrite(1'b1, 8'h55);
    check("R5 write at count 11 early", resetReq, 1'b1);
    idle(2);
    doWrite(1'b0, 8'h09);
    idle(12);
    doWrite(1'b1, 8'h55);
    check("R5 write at count 12 accepted", resetReq, 1'b0);
    doWrite(1'b1, 8'hAA);
    check("R5 window key no request", resetReq, 1'b0);
    expectTimeout("R5 window key restarts", P1, 0);
  endtask

  task automatic testGate();
    doWrite(1'b0, 8'h01);
    idle(5);
    clkGate = 1'b1;
    idle(50);
    check("R6 gated no timeout", resetReq, 1'b0);
    clkGate = 1'b0;
    expectTimeout("R6 count held while gated", P1, 5);
  endtask

  task automatic testCtrlClear();
    doWrite(1'b0, 8'h01);
    idle(10);
    doWrite(1'b0, 8'h01);
    expectTimeout("R8 control write clears count", P1, 0);
    doWrite(1'b0, 8'h01);
    doWrite(1'b1, 8'h55);
    doWrite(1'b0, 8'h01);
    doWrite(1'b1, 8'hAA);
    expectTimeout("R8 control write clears key state", P1, 1);
  endtask

  initial begin
    idle(3);
    check("reset state", resetReq, 1'b0);
    rstN = 1'b1;
    idle(2);
    check("after reset release", resetReq, 1'b0);
    testDisabled();
    testPeriods();
    testService();
    testBadKey();
    testWindow();
    testGate();
    testCtrlClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule